// File: doc/BRIEF.md
# Guarded Rule Executor with Priority Scheduling

This block runs guarded atomic actions against a small bank of shared registers. Each of N rules presents three things. The first is an explicit guard bit. The second is a group of readiness bits for the interfaces it depends on. The third is, for every one of the R registers, a proposed next value and a write-mask bit. A rule may fire only when its guard and all of its readiness bits are high. A fixed-priority scheduler then admits at most one such rule per clock, so the register bank changes exactly as if rules ran one at a time.

Logic that computes rule bodies feeds the proposed values. That logic reads the register outputs of the current cycle. The executor forms each register's write enable from the grant. It steers the winning rule's value into every register that the winner's mask selects. Registers outside that mask keep their contents. The grant vector is an output, so the rest of the design can see which rule fired.

Top module: `rule_exec`

## Requirements
- R1: A rule is eligible (can fire) exactly when its guard bit is high and every one of its NRDY readiness bits is high. Rule i's readiness bits are `ready_i[i*NRDY +: NRDY]`.
- R2: `will_fire_o` equals the lowest-numbered eligible rule as a one-hot vector, with bit i standing for rule i. Rule 0 has the highest priority. `will_fire_o` is all zero when no rule is eligible. The output is combinational from the current inputs.
- R3: At most one bit of `will_fire_o` is high in any cycle.
- R4: At the clock edge, register r takes rule i's proposed value `wdata_i[(i*R+r)*W +: W]` when rule i fires and its mask bit `wmask_i[i*R+r]` is 1. Register r appears on `regs_o[r*W +: W]`.
- R5: A register keeps its value across an edge when the firing rule has its mask bit clear, or when no rule fires.
- R6: An eligible rule that loses arbitration changes no register, even where its mask bits are set.
- R7: While `rst_n` is low, `will_fire_o` is zero. A clock edge with `rst_n` low loads every register from the INIT_VALUE parameter. The default for each register is 8'h55.
- R8: Proposed values may be computed from the current register outputs. All writes of one firing commit together at the same edge, so one rule can exchange two registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| guard_i | input | N | Explicit guard bit per rule |
| ready_i | input | N*NRDY | Readiness bits, NRDY per rule |
| wmask_i | input | N*R | Write-mask, R bits per rule |
| wdata_i | input | N*R*W | Proposed register values, R per rule |
| regs_o | output | R*W | Current register contents |
| will_fire_o | output | N | One-hot grant of the firing rule, or zero |

## Verification
The hardest situation to reach from the ports has several rules eligible at once. The winner writes nothing, or only part of the bank, while a lower-priority rule has its mask set on the registers the winner leaves alone. Only that case tells a correct design apart from one that lets losing rules leak writes. Directed cycles build this case explicitly. Random cycles bias readiness bits toward one, so that ties are frequent. The exchange case feeds proposed values taken straight from the register outputs, to show that both writes commit at the same edge.

// File: rtl/rule_exec_pkg.sv
package rule_exec_pkg;
    localparam int MAX_RULES = 8;

    typedef logic [MAX_RULES-1:0] rule_vec_t;

    // Isolates the least significant set bit.
    function automatic rule_vec_t lowest_set(input rule_vec_t v);
        return v & (~v + rule_vec_t'(1));
    endfunction
endpackage

// File: rtl/rule_guard.sv
module rule_guard #(
    parameter int N    = 4,
    parameter int NRDY = 2
) (
    input  logic [N-1:0]      guard,
    input  logic [N*NRDY-1:0] ready,
    output logic [N-1:0]      can_fire
);
    for (genvar i = 0; i < N; i++) begin : g_rule
        assign can_fire[i] = guard[i] & (&ready[i*NRDY +: NRDY]);
    end
endmodule

// File: rtl/rule_sched.sv
module rule_sched
    import rule_exec_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         run,
    input  logic [N-1:0] can_fire,
    output logic [N-1:0] will_fire
);
    rule_vec_t padded;
    rule_vec_t picked;

    always_comb begin
        padded = '0;
        padded[N-1:0] = can_fire;
        picked = lowest_set(padded);
    end

    assign will_fire = run ? picked[N-1:0] : '0;
endmodule

// File: rtl/rule_regslot.sv
module rule_regslot #(
    parameter int          N    = 4,
    parameter int          W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   will_fire,
    input  logic [N-1:0]   mask_col,
    input  logic [N*W-1:0] data_col,
    output logic           wr_en,
    output logic [W-1:0]   q
);
    logic [W-1:0] nxt;

    assign wr_en = |(will_fire & mask_col);

    always_comb begin
        nxt = '0;
        for (int i = 0; i < N; i++) begin
            if (will_fire[i] && mask_col[i]) begin
                nxt = nxt | data_col[i*W +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (wr_en) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/rule_exec.sv
module rule_exec
    import rule_exec_pkg::*;
#(
    parameter int            N          = 4,
    parameter int            R          = 4,
    parameter int            W          = 8,
    parameter int            NRDY       = 2,
    parameter logic [R*W-1:0] INIT_VALUE = {(R*W/4){4'h5}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      guard_i,
    input  logic [N*NRDY-1:0] ready_i,
    input  logic [N*R-1:0]    wmask_i,
    input  logic [N*R*W-1:0]  wdata_i,
    output logic [R*W-1:0]    regs_o,
    output logic [N-1:0]      will_fire_o
);
    logic [N-1:0] can_fire;
    logic [R-1:0] wr_en;

    rule_guard #(.N(N), .NRDY(NRDY)) u_guard (
        .guard    (guard_i),
        .ready    (ready_i),
        .can_fire (can_fire)
    );

    rule_sched #(.N(N)) u_sched (
        .run       (rst_n),
        .can_fire  (can_fire),
        .will_fire (will_fire_o)
    );

    for (genvar r = 0; r < R; r++) begin : g_reg
        logic [N-1:0]   mcol;
        logic [N*W-1:0] dcol;
        for (genvar i = 0; i < N; i++) begin : g_col
            assign mcol[i]          = wmask_i[i*R + r];
            assign dcol[i*W +: W]   = wdata_i[(i*R + r)*W +: W];
        end
        rule_regslot #(.N(N), .W(W), .INIT(INIT_VALUE[r*W +: W])) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .will_fire (will_fire_o),
            .mask_col  (mcol),
            .data_col  (dcol),
            .wr_en     (wr_en[r]),
            .q         (regs_o[r*W +: W])
        );
    end
endmodule

// File: rtl/rule_exec_chk.sv
module rule_exec_chk #(
    parameter int            N          = 4,
    parameter int            R          = 4,
    parameter int            W          = 8,
    parameter logic [R*W-1:0] INIT_VALUE = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     can_fire,
    input logic [N-1:0]     will_fire,
    input logic [N*R-1:0]   wmask,
    input logic [N*R*W-1:0] wdata,
    input logic [R*W-1:0]   regs,
    input logic [R-1:0]     wr_en
);
    // R3: grant is one-hot or zero
    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(will_fire));

    // R2: grant only for eligible rules, none lower-numbered is eligible
    assert_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (will_fire & ~can_fire) == '0);
    assert_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (will_fire != '0) |-> (((will_fire - N'(1)) & can_fire) == '0));
    assert_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (can_fire != '0) |-> (will_fire != '0));

    // R7: reset loads the initial contents
    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |=> (regs == INIT_VALUE));

    for (genvar r = 0; r < R; r++) begin : g_r
        // R5: register with no enable holds
        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[r] |=> (regs[r*W +: W] == $past(regs[r*W +: W])));
        for (genvar i = 0; i < N; i++) begin : g_i
            // R4: firing rule's value lands in each masked register
            assert_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (will_fire[i] && wmask[i*R + r]) |=>
                    (regs[r*W +: W] == $past(wdata[(i*R + r)*W +: W])));
        end
    end
endmodule

bind rule_exec rule_exec_chk #(.N(N), .R(R), .W(W), .INIT_VALUE(INIT_VALUE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .can_fire  (can_fire),
    .will_fire (will_fire_o),
    .wmask     (wmask_i),
    .wdata     (wdata_i),
    .regs      (regs_o),
    .wr_en     (wr_en)
);

// File: tb/sim_rule_exec.sv
`timescale 1ns/1ps
module sim_rule_exec;
    localparam int N = 4, R = 4, W = 8, NRDY = 2;
    localparam logic [R*W-1:0] INIT = {R{8'h55}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      guard_i = '0;
    logic [N*NRDY-1:0] ready_i = '0;
    logic [N*R-1:0]    wmask_i = '0;
    logic [N*R*W-1:0]  wdata_i = '0;
    logic [R*W-1:0]    regs_o;
    logic [N-1:0]      will_fire_o;

    int tests = 0, fails = 0;
    logic [R*W-1:0] model;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rule_exec #(.N(N), .R(R), .W(W), .NRDY(NRDY)) u0 (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_grant(input logic [N-1:0] g, input logic [N*NRDY-1:0] rd);
        logic [N-1:0] cf;
        for (int i = 0; i < N; i++) cf[i] = g[i] & (&rd[i*NRDY +: NRDY]);
        return cf & (~cf + N'(1));
    endfunction

    function automatic logic [R*W-1:0] exp_next(input logic [R*W-1:0] cur, input logic [N-1:0] wf,
                                                input logic [N*R-1:0] m, input logic [N*R*W-1:0] d);
        logic [R*W-1:0] nx = cur;
        for (int i = 0; i < N; i++)
            for (int r = 0; r < R; r++)
                if (wf[i] && m[i*R + r]) nx[r*W +: W] = d[(i*R + r)*W +: W];
        return nx;
    endfunction

    // Called just after a falling edge; ends just after the next falling edge.
    task automatic run_cycle(input logic [N-1:0] g, input logic [N*NRDY-1:0] rd,
                             input logic [N*R-1:0] m, input logic [N*R*W-1:0] d, input string req);
        logic [N-1:0] ewf;
        guard_i = g; ready_i = rd; wmask_i = m; wdata_i = d;
        #1;
        ewf = exp_grant(g, rd);
        check(will_fire_o == ewf, {req, " grant"}, 64'(will_fire_o), 64'(ewf));
        model = exp_next(model, ewf, m, d);
        @(negedge clk);
        check(regs_o == model, {req, " regs"}, 64'(regs_o), 64'(model));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [N*R*W-1:0] d;
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        // R7: reset with every rule eligible
        guard_i = '1; ready_i = '1; wmask_i = '1; wdata_i = '1;
        @(negedge clk);
        check(will_fire_o == '0, "R7 grant in reset", 64'(will_fire_o), 0);
        @(negedge clk);
        check(regs_o == INIT, "R7 init", 64'(regs_o), 64'(INIT));
        model = INIT;
        rst_n = 1'b1;

        // R2: no rule eligible
        run_cycle('0, '1, '1, '1, "R2 idle");
        // R1: guard high but one ready bit low on rules 0 and 1, rule 2 wins
        run_cycle(4'b0111, 8'b11_11_10_01, '1, {16{8'h3C}}, "R1 ready");
        // R2/R3: all eligible, rule 0 wins, writes reg1 only
        d = '0; d[(0*R+1)*W +: W] = 8'hA1;
        run_cycle('1, '1, 16'hFFF2, d | {16{8'h0F}} & ~(128'hFF << ((0*R+1)*W)), "R3 all eligible");
        // R6: rule 0 wins with empty mask, rule 2 masks everything
        run_cycle(4'b0101, '1, 16'h0F00, {16{8'hEE}}, "R6 loser silent");
        // R5: rule 3 alone writes reg0 and reg3
        run_cycle(4'b1000, '1, 16'h9000, {16{8'h77}}, "R5 partial mask");
        // R8: rule 1 exchanges reg0 and reg1 using current outputs
        run_cycle(4'b0010, '1, 16'h0030, {16{8'h11}}, "R4 seed");
        d = '0;
        d[(1*R+0)*W +: W] = regs_o[1*W +: W];
        d[(1*R+1)*W +: W] = regs_o[0*W +: W];
        run_cycle(4'b0010, '1, 16'h0030, d, "R8 exchange");
        run_cycle(4'b0010, '1, 16'h0000, d, "R5 empty mask");

        // R4/R2: random traffic with biased readiness
        for (int k = 0; k < 400; k++) begin
            logic [N*R*W-1:0] rd_data;
            for (int j = 0; j < N*R*W/32; j++) rd_data[j*32 +: 32] = $urandom;
            run_cycle(N'($urandom), (N*NRDY)'($urandom | $urandom), (N*R)'($urandom),
                      rd_data, "R4 random");
        end

        // R7: reset again mid-run
        rst_n = 1'b0; guard_i = '1; ready_i = '1;
        #1;
        check(will_fire_o == '0, "R7 grant in reset again", 64'(will_fire_o), 0);
        @(negedge clk);
        check(regs_o == INIT, "R7 reinit", 64'(regs_o), 64'(INIT));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule